// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level command engine on the slave side of a serial NOR flash. A bit shifter in front of it delivers each byte received from the bus master as a one-cycle strobe, and the sequencer returns, in that same cycle, the byte to be shifted back. The sequencer decodes the opcode and gathers the address bytes. It then walks through the program, read, status or identification phase. Writes and erases go out as one-cycle requests to a separate array engine. Array bytes are read through a combinational address/data pair.

The byte strobe is a valid-only stream with no ready. The serial master cannot be stalled, so the block must accept a byte on every cycle that the strobe is high. The array read path must return data in the cycle the address is presented. Requests to the array engine are pulses, and the engine takes them without back-pressure. Device size, the 24-bit identification code, the optional 16-bit extended code and the number of dummy bytes for fast read are parameters.

Top module: `spi_nor_cmd_seq`

## Requirements
- R1: While the device is selected, the byte after idle is decoded as an opcode: 0x02 program, 0x03 read, 0x0B fast read, 0x04 latch clear, 0x06 latch set, 0x05 status, 0x9F identification, 0x20/0x52/0xD8 block erases, 0xC7 whole-device erase. Any other value, 0x00 included, leaves the block idle. The byte returned during opcode and address phases is 0x00.
- R2: Read, program and the three block erases take 3 address bytes, assembled most significant first (bits 23:16, then 15:8, then 7:0). Fast read takes those 3 plus FAST_DUMMY dummy bytes (default 1), whose values are ignored.
- R3: After a read or fast-read address, each strobe returns the array byte at the current address, and the address then advances. It goes from DEV_BYTES-1 back to 0.
- R4: After a program address, each strobe with the write latch set raises a program request carrying the current address and the received byte. The address advances with the same wrap as R3. With the latch clear, no request is raised.
- R5: Opcode 0x06 sets the write latch and 0x04 clears it. The status command returns one byte, 0x02 when the latch is set and 0x00 otherwise, then goes idle.
- R6: Identification returns ID_CODE[23:16], ID_CODE[15:8] and ID_CODE[7:0]. If EXT_ID is nonzero, EXT_ID[15:8] and EXT_ID[7:0] follow. After the last byte the block goes idle.
- R7: With the latch set, an erase request is raised with kind code 0 (0x20), 1 (0x52) or 2 (0xD8) and the collected address, once the third address byte arrives. Kind 3 with address 0 is raised on the 0xC7 opcode byte itself. With the latch clear, no erase request is raised. The block is idle after any erase command.
- R8: While chip select is high, the block is held idle with its byte counters cleared, and strobes are ignored. The first byte after select is always an opcode.
- R9: Program and erase requests are single-cycle pulses, raised in the cycle after the strobe that causes them, and never both in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| byte_stb | input | 1 | One-cycle valid for byte_in (no ready) |
| byte_in | input | 8 | Byte received from the master |
| byte_out | output | 8 | Reply byte, valid in the strobe cycle, 0 otherwise |
| arr_addr | output | 24 | Array read address |
| arr_rdata | input | 8 | Array byte at arr_addr, same cycle |
| prog_req | output | 1 | Program-byte request pulse |
| prog_addr | output | 24 | Program address |
| prog_data | output | 8 | Program data |
| erase_req | output | 1 | Erase request pulse |
| erase_kind | output | 2 | 0: 4 KiB, 1: 32 KiB, 2: sector, 3: whole device |
| erase_addr | output | 24 | Erase address |

## Verification
The assertions assume a strobe is never raised while the block is held in reset. They also assume that read addresses stay below DEV_BYTES, which the wrap property relies on to reach the last byte. The bench drives only addresses inside its 256-byte array model, and it changes chip select and strobe one time unit after a rising edge, so every byte is consumed by exactly one edge. Abandoned commands are produced by deselecting in the middle of an address phase. Strobes while deselected are produced by raising the strobe with chip select high.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PROG, ST_READ, ST_STAT, ST_ID
  } seq_state_e;

  typedef enum logic [3:0] {
    K_NONE, K_PROG, K_READ, K_FREAD, K_LCLR, K_STAT, K_LSET,
    K_E4K, K_E32K, K_ESEC, K_IDENT, K_EALL
  } cmd_kind_e;

  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_LCLR  = 8'h04;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_LSET  = 8'h06;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_E4K   = 8'h20;
  localparam logic [7:0] OP_E32K  = 8'h52;
  localparam logic [7:0] OP_ESEC  = 8'hD8;
  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam logic [7:0] OP_EALL  = 8'hC7;

  localparam logic [1:0] ERK_4K   = 2'd0;
  localparam logic [1:0] ERK_32K  = 2'd1;
  localparam logic [1:0] ERK_SECT = 2'd2;
  localparam logic [1:0] ERK_ALL  = 2'd3;

  function automatic logic [1:0] erase_code(cmd_kind_e k);
    case (k)
      K_E4K:   return ERK_4K;
      K_E32K:  return ERK_32K;
      K_ESEC:  return ERK_SECT;
      default: return ERK_ALL;
    endcase
  endfunction

endpackage

// File: rtl/spi_nor_opdecode.sv
module spi_nor_opdecode
  import spi_nor_pkg::*;
#(
  parameter int unsigned FAST_DUMMY = 1,
  parameter int unsigned CNT_W      = 3
) (
  input  logic [7:0]       opcode,
  output cmd_kind_e        kind,
  output logic [CNT_W-1:0] need
);
  localparam logic [CNT_W-1:0] ADDR_LEN = CNT_W'(3);
  localparam logic [CNT_W-1:0] FAST_LEN = CNT_W'(3 + FAST_DUMMY);

  always_comb begin
    need = '0;
    case (opcode)
      OP_PROG:  begin kind = K_PROG;  need = ADDR_LEN; end
      OP_READ:  begin kind = K_READ;  need = ADDR_LEN; end
      OP_FREAD: begin kind = K_FREAD; need = FAST_LEN; end
      OP_E4K:   begin kind = K_E4K;   need = ADDR_LEN; end
      OP_E32K:  begin kind = K_E32K;  need = ADDR_LEN; end
      OP_ESEC:  begin kind = K_ESEC;  need = ADDR_LEN; end
      OP_LCLR:  kind = K_LCLR;
      OP_LSET:  kind = K_LSET;
      OP_STAT:  kind = K_STAT;
      OP_IDENT: kind = K_IDENT;
      OP_EALL:  kind = K_EALL;
      default:  kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/spi_nor_reply.sv
module spi_nor_reply
  import spi_nor_pkg::*;
#(
  parameter logic [23:0] ID_CODE = 24'h5A3C17,
  parameter logic [15:0] EXT_ID  = 16'h0000,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             stb,
  input  seq_state_e       state,
  input  logic [CNT_W-1:0] idx,
  input  logic             wel,
  input  logic [7:0]       rd_data,
  output logic [7:0]       tx
);
  logic [7:0] id_byte;

  generate
    if (EXT_ID != 16'h0000) begin : g_ext
      always_comb begin
        case (idx)
          CNT_W'(0): id_byte = ID_CODE[23:16];
          CNT_W'(1): id_byte = ID_CODE[15:8];
          CNT_W'(2): id_byte = ID_CODE[7:0];
          CNT_W'(3): id_byte = EXT_ID[15:8];
          default:   id_byte = EXT_ID[7:0];
        endcase
      end
    end else begin : g_base
      always_comb begin
        case (idx)
          CNT_W'(0): id_byte = ID_CODE[23:16];
          CNT_W'(1): id_byte = ID_CODE[15:8];
          default:   id_byte = ID_CODE[7:0];
        endcase
      end
    end
  endgenerate

  always_comb begin
    tx = 8'h00;
    if (stb) begin
      case (state)
        ST_READ: tx = rd_data;
        ST_STAT: tx = {6'b0, wel, 1'b0};
        ST_ID:   tx = id_byte;
        default: tx = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/spi_nor_cmd_seq.sv
module spi_nor_cmd_seq
  import spi_nor_pkg::*;
#(
  parameter int unsigned DEV_BYTES  = 1 << 21,
  parameter logic [23:0] ID_CODE    = 24'h5A3C17,
  parameter logic [15:0] EXT_ID     = 16'h0000,
  parameter int unsigned FAST_DUMMY = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        byte_stb,
  input  logic [7:0]  byte_in,
  output logic [7:0]  byte_out,
  output logic [23:0] arr_addr,
  input  logic [7:0]  arr_rdata,
  output logic        prog_req,
  output logic [23:0] prog_addr,
  output logic [7:0]  prog_data,
  output logic        erase_req,
  output logic [1:0]  erase_kind,
  output logic [23:0] erase_addr
);
  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned ID_LEN   = (EXT_ID != 16'h0000) ? 5 : 3;
  localparam int unsigned MAX_SEQ  = ((3 + FAST_DUMMY) > ID_LEN) ? (3 + FAST_DUMMY) : ID_LEN;
  localparam int unsigned CNT_W    = $clog2(MAX_SEQ + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEV_BYTES - 1);
  localparam logic [CNT_W-1:0]  ID_LAST   = CNT_W'(ID_LEN - 1);

  seq_state_e        state_q;
  cmd_kind_e         kind_q, dec_kind;
  logic [CNT_W-1:0]  cnt_q, need_q, dec_need;
  logic [ADDR_W-1:0] addr_q, addr_shift, addr_inc;
  logic              wel_q;
  logic              take;

  assign take       = byte_stb && !cs_n;
  assign addr_shift = {addr_q[15:0], byte_in};
  assign addr_inc   = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
  assign arr_addr   = addr_q;

  spi_nor_opdecode #(.FAST_DUMMY(FAST_DUMMY), .CNT_W(CNT_W)) u_dec (
    .opcode (byte_in),
    .kind   (dec_kind),
    .need   (dec_need)
  );

  spi_nor_reply #(.ID_CODE(ID_CODE), .EXT_ID(EXT_ID), .CNT_W(CNT_W)) u_reply (
    .stb     (take),
    .state   (state_q),
    .idx     (cnt_q),
    .wel     (wel_q),
    .rd_data (arr_rdata),
    .tx      (byte_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      kind_q     <= K_NONE;
      cnt_q      <= '0;
      need_q     <= '0;
      addr_q     <= '0;
      wel_q      <= 1'b0;
      prog_req   <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      erase_req  <= 1'b0;
      erase_kind <= '0;
      erase_addr <= '0;
    end else begin
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      if (cs_n) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (byte_stb) begin
        case (state_q)
          ST_IDLE: begin
            cnt_q  <= '0;
            kind_q <= dec_kind;
            need_q <= dec_need;
            case (dec_kind)
              K_PROG, K_READ, K_FREAD, K_E4K, K_E32K, K_ESEC: state_q <= ST_ADDR;
              K_LSET:  wel_q <= 1'b1;
              K_LCLR:  wel_q <= 1'b0;
              K_STAT:  state_q <= ST_STAT;
              K_IDENT: state_q <= ST_ID;
              K_EALL: if (wel_q) begin
                erase_req  <= 1'b1;
                erase_kind <= ERK_ALL;
                erase_addr <= '0;
              end
              default: ;
            endcase
          end
          ST_ADDR: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q < CNT_W'(3)) addr_q <= addr_shift;
            if (cnt_q == need_q - 1'b1) begin
              cnt_q <= '0;
              case (kind_q)
                K_PROG:          state_q <= ST_PROG;
                K_READ, K_FREAD: state_q <= ST_READ;
                default: begin
                  state_q <= ST_IDLE;
                  if (wel_q) begin
                    erase_req  <= 1'b1;
                    erase_kind <= erase_code(kind_q);
                    erase_addr <= (cnt_q < CNT_W'(3)) ? addr_shift : addr_q;
                  end
                end
              endcase
            end
          end
          ST_PROG: begin
            if (wel_q) begin
              prog_req  <= 1'b1;
              prog_addr <= addr_q;
              prog_data <= byte_in;
            end
            addr_q <= addr_inc;
          end
          ST_READ: addr_q <= addr_inc;
          ST_STAT: state_q <= ST_IDLE;
          ST_ID: begin
            if (cnt_q == ID_LAST) begin
              state_q <= ST_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R8: a deselected device is idle on the next cycle
  p_desel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> state_q == ST_IDLE);

  // R1: opcode and address phases answer with zero
  p_quiet_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (state_q == ST_IDLE || state_q == ST_ADDR)) |-> byte_out == 8'h00);

  // R7: erase only under a set latch
  p_erase_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> wel_q);

  // R4: program only under a set latch
  p_prog_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> wel_q);

  // R3: read address wraps at the end of the device
  p_read_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && state_q == ST_READ && addr_q == LAST_ADDR) |=> addr_q == '0);

  // R9: at most one request per cycle, each a single pulse
  p_one_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req}));
  p_prog_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(take && state_q == ST_PROG));

  // R5: status byte carries only the latch bit
  p_stat_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && state_q == ST_STAT) |-> (byte_out & 8'hFD) == 8'h00);
endmodule

// File: tb/spi_nor_cmd_seq_tb.sv
module spi_nor_cmd_seq_tb;
  localparam int CLK_NS = 10;
  localparam int DEV    = 256;
  localparam logic [23:0] IDC = 24'h5A3C17;
  localparam logic [15:0] EXT = 16'h4D21;

  logic clk = 0, rst_n = 0, cs_n = 1, stb = 0;
  logic [7:0] rx = 0;
  logic [7:0] tx, tx3, rd, rd3;
  logic [23:0] aa, aa3, pa, pa3, ea, ea3;
  logic pr, pr3, er, er3;
  logic [7:0] pd, pd3;
  logic [1:0] ek, ek3;
  logic [7:0] mem [DEV];

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign rd  = mem[aa[7:0]];
  assign rd3 = mem[aa3[7:0]];

  spi_nor_cmd_seq #(.DEV_BYTES(DEV), .ID_CODE(IDC), .EXT_ID(EXT), .FAST_DUMMY(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_stb(stb), .byte_in(rx), .byte_out(tx),
    .arr_addr(aa), .arr_rdata(rd), .prog_req(pr), .prog_addr(pa), .prog_data(pd),
    .erase_req(er), .erase_kind(ek), .erase_addr(ea));

  spi_nor_cmd_seq #(.DEV_BYTES(DEV), .ID_CODE(IDC), .EXT_ID(16'h0000), .FAST_DUMMY(1)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_stb(stb), .byte_in(rx), .byte_out(tx3),
    .arr_addr(aa3), .arr_rdata(rd3), .prog_req(pr3), .prog_addr(pa3), .prog_data(pd3),
    .erase_req(er3), .erase_kind(ek3), .erase_addr(ea3));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 address,2 program,3 read,4 status,5 ident
  int ph = 0, nb = 0, need = 0, op = 0, adr = 0, wl = 0;
  int x_pr = 0, x_pa = 0, x_pd = 0, x_er = 0, x_ek = 0, x_ea = 0;

  function automatic int id_at(int i);
    case (i)
      0: return IDC[23:16];
      1: return IDC[15:8];
      2: return IDC[7:0];
      3: return EXT[15:8];
      default: return EXT[7:0];
    endcase
  endfunction

  always @(posedge clk) begin
    x_pr = 0; x_er = 0;
    if (!rst_n) begin
      ph = 0; nb = 0; adr = 0; wl = 0;
    end else if (cs_n) begin
      ph = 0; nb = 0;
    end else if (stb) begin
      case (ph)
        0: begin
          op = rx; nb = 0;
          if (rx == 8'h02 || rx == 8'h03 || rx == 8'h20 || rx == 8'h52 || rx == 8'hD8) begin ph = 1; need = 3; end
          else if (rx == 8'h0B) begin ph = 1; need = 4; end
          else if (rx == 8'h04) wl = 0;
          else if (rx == 8'h06) wl = 1;
          else if (rx == 8'h05) ph = 4;
          else if (rx == 8'h9F) ph = 5;
          else if (rx == 8'hC7 && wl == 1) begin x_er = 1; x_ek = 3; x_ea = 0; end
        end
        1: begin
          if (nb < 3) adr = ((adr << 8) | rx) & 24'hFFFFFF;
          nb++;
          if (nb == need) begin
            nb = 0;
            if (op == 8'h02) ph = 2;
            else if (op == 8'h03 || op == 8'h0B) ph = 3;
            else begin
              ph = 0;
              if (wl == 1) begin
                x_er = 1; x_ea = adr;
                x_ek = (op == 8'h20) ? 0 : (op == 8'h52) ? 1 : 2;
              end
            end
          end
        end
        2: begin
          if (wl == 1) begin x_pr = 1; x_pa = adr; x_pd = rx; end
          adr = (adr + 1) % DEV;
        end
        3: adr = (adr + 1) % DEV;
        4: ph = 0;
        default: begin nb++; if (nb == 5) begin ph = 0; nb = 0; end end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stb && !cs_n) begin
        int e;
        string t;
        case (ph)
          3: begin e = mem[adr % DEV]; t = "R3 read byte"; end
          4: begin e = wl << 1;        t = "R5 status byte"; end
          5: begin e = id_at(nb);      t = "R6 ident byte"; end
          default: begin e = 0;        t = "R1 quiet reply"; end
        endcase
        check(tx == 8'(e), t, tx, e);
      end
      check(pr == x_pr[0], "R4/R9 program pulse", pr, x_pr);
      if (x_pr == 1) check(pa == 24'(x_pa) && pd == 8'(x_pd), "R4 program payload", {pa, pd}, {x_pa[23:0], x_pd[7:0]});
      check(er == x_er[0], "R7/R9 erase pulse", er, x_er);
      if (x_er == 1) check(ek == 2'(x_ek) && ea == 24'(x_ea), "R7 erase payload", {ek, ea}, {x_ek[1:0], x_ea[23:0]});
    end
  end

  task automatic send(input logic [7:0] b);
    @(posedge clk); #1; stb = 1; rx = b;
    @(negedge clk);
  endtask

  task automatic sel();
    @(posedge clk); #1; stb = 0; cs_n = 0;
  endtask

  task automatic desel();
    @(posedge clk); #1; stb = 0; cs_n = 1;
  endtask

  task automatic status_expect(input int e, input string tag);
    sel(); send(8'h05); send(8'h00);
    check(tx == 8'(e), tag, tx, e);
    desel();
  endtask

  initial begin
    for (int i = 0; i < DEV; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(tx == 8'h00 && !pr && !er, "R1 reset outputs quiet", {tx, pr, er}, 0);

    // R5 latch and status
    status_expect(0, "R5 status after reset");
    sel(); send(8'h06); desel();
    status_expect(2, "R5 status after latch set");
    sel(); send(8'h04); desel();
    status_expect(0, "R5 status after latch clear");

    // R4 program with latch clear: nothing requested
    sel(); send(8'h02); send(8'h00); send(8'h00); send(8'h40); send(8'hA5); send(8'h5A); desel();

    // R4 program with latch set
    sel(); send(8'h06); desel();
    sel(); send(8'h02); send(8'h00); send(8'h00); send(8'hFE);
    send(8'h12); send(8'h34); send(8'h56); desel();

    // R2/R3 read with wrap
    sel(); send(8'h03); send(8'h00); send(8'h00); send(8'hFC);
    @(posedge clk); #1 stb = 0;
    @(negedge clk);
    check(aa == 24'h0000FC, "R2 assembled read address", aa, 24'hFC);
    for (int i = 0; i < 8; i++) send(8'hFF);
    desel();

    // R2 fast read with dummy byte
    sel(); send(8'h0B); send(8'h00); send(8'h00); send(8'h10); send(8'h77);
    @(posedge clk); #1 stb = 0;
    @(negedge clk);
    check(aa == 24'h000010, "R2 dummy byte leaves address", aa, 24'h10);
    for (int i = 0; i < 3; i++) send(8'h00);
    desel();

    // R6 identification on both variants
    sel(); send(8'h9F);
    for (int i = 0; i < 5; i++) begin
      send(8'h00);
      if (i < 3) check(tx3 == 8'(id_at(i)), "R6 short ident byte", tx3, id_at(i));
      else check(tx3 == 8'h00, "R6 short ident then idle", tx3, 0);
    end
    send(8'h00);
    desel();

    // R7 erases with latch set (still set)
    sel(); send(8'h20); send(8'h01); send(8'h23); send(8'h45); desel();
    sel(); send(8'h52); send(8'h00); send(8'h80); send(8'h00); desel();
    sel(); send(8'hD8); send(8'h0A); send(8'h00); send(8'h00); send(8'h05); send(8'h00); desel();
    sel(); send(8'hC7); desel();
    sel(); send(8'h04); desel();
    sel(); send(8'hC7); desel();
    sel(); send(8'h20); send(8'h00); send(8'h10); send(8'h00); desel();

    // R1 unknown opcode stays idle, next byte is an opcode
    sel(); send(8'hAB); send(8'h00); send(8'h05); send(8'h00);
    check(tx == 8'h00, "R1 unknown then status", tx, 0);
    desel();

    // R8 abort mid-address, then strobes while deselected
    sel(); send(8'h03); send(8'h00); desel();
    status_expect(0, "R8 select restarts at opcode");
    @(posedge clk); #1; cs_n = 1; stb = 1; rx = 8'h06;
    @(posedge clk); #1; stb = 0;
    status_expect(0, "R8 strobe while deselected ignored");
    @(negedge clk);
    check(tx == 8'h00, "R8 deselected reply zero", tx, 0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule